// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block is a single-bank read/write cache that sits between a requesting core and a slower byte-wide backing memory. Each requester address is cut into three fields: the low bits pick a byte within a line, the middle bits pick one line, and the upper bits are kept as a tag. One stored tag, one valid bit and one comparator decide whether the access hits. The data byte is read from the bank and chosen by the offset at the same time as the tag compare, so no way-select multiplexer follows the compare.

Read hits finish in the cycle they are presented. A read miss stalls the requester while the controller fetches the whole line from memory, one beat per byte in ascending address order, and then completes the read from the refilled line. Every write goes straight to memory. A write that hits also updates the cached byte in the cycle memory acknowledges. A write that misses leaves the cache untouched. The line count, line size, address width and data width are parameters.

The controller has three states. `ST_IDLE` serves read hits and takes `IDLE->FILL` on a read miss and `IDLE->WRITE` on any write. `ST_FILL` issues one memory read per beat and takes `FILL->IDLE` when the last beat is acknowledged. `ST_WRITE` holds one memory write and takes `WRITE->IDLE` on its acknowledge.

Top module: `dm_wt_cache`

## Requirements
- R1: With OFF_W = log2(LINE_BYTES) and IDX_W = log2(LINES), the offset is addr[OFF_W-1:0], the index is the next IDX_W bits, and the tag is all remaining upper bits. The defaults give a 5-bit tag, a 2-bit index and a 1-bit offset.
- R2: Reset clears every valid bit, so the first read of any address after reset misses. While reset is held and no request is present, ready and mem_req are 0.
- R3: A read whose indexed line is valid with an equal tag raises ready in the same cycle as req. It returns the stored byte selected by the offset and raises no memory request.
- R4: A read miss holds ready low and fetches LINE_BYTES beats. Each beat is a mem_req with mem_we=0, starting at the line base (offset 0) and ascending. Each beat is accepted on mem_ack with its data on mem_rdata. One cycle after the last beat the read completes with the fetched byte.
- R5: A miss replaces whatever line occupied its index. A later read of the evicted address misses again (conflict miss).
- R6: Every write issues exactly one memory write (mem_req=1, mem_we=1) carrying the requester's address and data. Ready rises in the cycle mem_ack is seen.
- R7: A write that hits updates the cached byte, so a following read of that address hits and returns the written value.
- R8: A write that misses performs no line fetch and does not disturb the line resident at that index.
- R9: Ready is only raised while req is high. A memory request keeps its address stable until it is acknowledged.
- R10: With default parameters and an empty cache, the read stream 0,1,12,2,3,4,12,5 produces exactly two hits (addresses 1 and 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request present; held with its fields until ready |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid when ready and we=0 |
| ready | output | 1 | Access completes this cycle |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Memory beat is a write |
| mem_addr | output | ADDR_W | Memory beat address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory accepts the current beat |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |

## Verification
On a write hit, the memory acknowledge and the cached byte update happen in the same cycle. In that cycle the requester also sees ready, and the cache must not return stale data afterwards. The bench provokes this by writing to a line made resident just before, then reading the same byte at once. It judges the result by a one-cycle hit returning the new value, with the backing memory holding that value as well. A write miss to an index whose line is resident is then judged by the resident line still hitting.

// File: rtl/dmwt_pkg.sv
package dmwt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WRITE = 2'd2
    } ctl_state_t;
endpackage

// File: rtl/dmwt_tag_store.sv
module dmwt_tag_store #(
    parameter int LINES = 4,
    parameter int IDX_W = 2,
    parameter int TAG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] tag,
    input  logic             fill_done,
    output logic             hit
);
    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // valid bits clear on reset (R2)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            valid_q <= '0;
        else if (fill_done)
            valid_q[idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (fill_done)
            tag_q[idx] <= tag;
    end

    // single comparator (R3)
    assign hit = valid_q[idx] && (tag_q[idx] == tag);
endmodule

// File: rtl/dmwt_data_store.sv
module dmwt_data_store #(
    parameter int LINES      = 4,
    parameter int LINE_BYTES = 2,
    parameter int DATA_W     = 8,
    parameter int IDX_W      = 2,
    parameter int OFF_W      = 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = LINES * LINE_BYTES;

    logic [DATA_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            bank[{idx, wr_off}] <= wr_data;
    end

    // read and offset select run beside the tag compare
    assign rd_data = bank[{idx, rd_off}];
endmodule

// File: rtl/dmwt_ctrl.sv
module dmwt_ctrl
    import dmwt_pkg::*;
#(
    parameter int LINE_BYTES = 2,
    parameter int OFF_W      = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             we,
    input  logic             hit,
    input  logic             mem_ack,
    output logic             ready,
    output logic             mem_req,
    output logic             mem_we,
    output logic [OFF_W-1:0] beat,
    output logic             beat_wr,
    output logic             fill_done,
    output logic             store_upd
);
    localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(LINE_BYTES - 1);

    ctl_state_t       state_q, state_d;
    logic [OFF_W-1:0] beat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FILL && mem_ack)
                beat_q <= (beat_q == LAST_BEAT) ? '0 : beat_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req && we)
                    state_d = ST_WRITE;
                else if (req && !hit)
                    state_d = ST_FILL;
            end
            ST_FILL: begin
                if (mem_ack && beat_q == LAST_BEAT)
                    state_d = ST_IDLE;
            end
            ST_WRITE: begin
                if (mem_ack)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ready     = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        beat_wr   = 1'b0;
        fill_done = 1'b0;
        store_upd = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready = req && !we && hit;
            end
            ST_FILL: begin
                mem_req   = 1'b1;
                beat_wr   = mem_ack;
                fill_done = mem_ack && (beat_q == LAST_BEAT);
            end
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                ready     = mem_ack;
                store_upd = mem_ack && hit;
            end
            default: ;
        endcase
    end

    assign beat = beat_q;
endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache #(
    parameter int ADDR_W     = 8,
    parameter int LINES      = 4,
    parameter int LINE_BYTES = 2,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    // address split (R1)
    logic [OFF_W-1:0] a_off;
    logic [IDX_W-1:0] a_idx;
    logic [TAG_W-1:0] a_tag;
    assign a_off = addr[OFF_W-1:0];
    assign a_idx = addr[OFF_W +: IDX_W];
    assign a_tag = addr[ADDR_W-1 -: TAG_W];

    logic             hit;
    logic [OFF_W-1:0] beat;
    logic             beat_wr, fill_done, store_upd;

    dmwt_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .idx(a_idx), .tag(a_tag),
        .fill_done(fill_done), .hit(hit)
    );

    dmwt_data_store #(
        .LINES(LINES), .LINE_BYTES(LINE_BYTES), .DATA_W(DATA_W),
        .IDX_W(IDX_W), .OFF_W(OFF_W)
    ) u_data (
        .clk(clk),
        .wr_en(beat_wr | store_upd),
        .idx(a_idx),
        .wr_off(beat_wr ? beat : a_off),
        .wr_data(beat_wr ? mem_rdata : wdata),
        .rd_off(a_off),
        .rd_data(rdata)
    );

    dmwt_ctrl #(.LINE_BYTES(LINE_BYTES), .OFF_W(OFF_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .hit(hit),
        .mem_ack(mem_ack), .ready(ready), .mem_req(mem_req),
        .mem_we(mem_we), .beat(beat), .beat_wr(beat_wr),
        .fill_done(fill_done), .store_upd(store_upd)
    );

    // writes go straight through; fills walk the line from offset 0
    assign mem_addr  = mem_we ? addr : {a_tag, a_idx, beat};
    assign mem_wdata = wdata;
endmodule

// File: rtl/dm_wt_cache_chk.sv
module dm_wt_cache_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int OFF_W  = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack
);
    assert_ready_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> req);

    assert_hit_no_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !we) |-> !mem_req);

    assert_write_through_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && we) |-> (mem_req && mem_we && mem_ack &&
                           mem_addr == addr && mem_wdata == wdata));

    assert_fill_own_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (req && !we &&
            mem_addr[ADDR_W-1:OFF_W] == addr[ADDR_W-1:OFF_W]));

    assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
endmodule

bind dm_wt_cache dm_wt_cache_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .ready(ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/sim_dm_wt_cache.sv
module sim_dm_wt_cache;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0, we = 1'b0;
    logic [7:0] addr = '0, wdata = '0;
    logic [7:0] rdata, mem_addr, mem_wdata;
    logic       ready, mem_req, mem_we;
    logic       mem_ack = 1'b0;
    logic [7:0] mem_rdata = '0;

    int tests = 0, fails = 0;
    int rd_beats = 0;
    logic [7:0] bmem [256];
    logic [7:0] flog [64];

    always #2 clk = ~clk;

    dm_wt_cache u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ready(ready), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // backing memory: one-cycle acknowledge per beat
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) bmem[i] <= 8'(i) ^ 8'hA5;
            mem_ack <= 1'b0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                mem_rdata <= bmem[mem_addr];
                if (mem_we) bmem[mem_addr] <= mem_wdata;
                else begin
                    flog[rd_beats % 64] <= mem_addr;
                    rd_beats <= rd_beats + 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [7:0] a, input logic [7:0] d,
                          output logic [7:0] r, output int cyc);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        #1;
        cyc = 1;
        while (!ready && cyc < 50) begin
            @(negedge clk); #1;
            cyc++;
        end
        r = rdata;
        @(posedge clk); #1;
        req = 1'b0; we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // read stream: {addr, expect hit}
    localparam logic [8:0] VEC [8] = '{
        {8'd0, 1'b0}, {8'd1, 1'b1}, {8'd12, 1'b0}, {8'd2, 1'b0},
        {8'd3, 1'b1}, {8'd4, 1'b0}, {8'd12, 1'b0}, {8'd5, 1'b0}
    };

    initial begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] r;
        int cyc, hits, b0;
        repeat (3) @(negedge clk);
        #1;
        check(ready == 1'b0, "R2 ready in reset", int'(ready), 0);
        check(mem_req == 1'b0, "R2 mem_req in reset", int'(mem_req), 0);
        rst_n = 1'b1;

        hits = 0;
        for (int i = 0; i < 8; i++) begin
            b0 = rd_beats;
            access(1'b0, VEC[i][8:1], 8'h00, r, cyc);
            if (cyc == 1) hits++;
            check(cyc == (VEC[i][0] ? 1 : 6), "R3/R4/R5 latency", cyc, VEC[i][0] ? 1 : 6);
            check(r == (VEC[i][8:1] ^ 8'hA5), "R3/R4 rdata", int'(r), int'(VEC[i][8:1] ^ 8'hA5));
            if (i == 2) begin
                // R1: addr 12 -> tag 1, index 2, fetched as 12 then 13
                check(flog[b0] == 8'd12 && flog[b0+1] == 8'd13, "R1 fetch order",
                      int'(flog[b0]), 12);
            end
            if (i == 7) begin
                check(flog[b0] == 8'd4 && flog[b0+1] == 8'd5, "R4 line base", int'(flog[b0]), 4);
            end
        end
        check(hits == 2, "R10 hit count", hits, 2);

        // write hit into line 1 (addresses 2,3 resident)
        b0 = rd_beats;
        access(1'b1, 8'd2, 8'h3C, r, cyc);
        check(cyc == 3, "R6 write latency", cyc, 3);
        check(bmem[2] == 8'h3C, "R6 memory written", int'(bmem[2]), 8'h3C);
        access(1'b0, 8'd2, 8'h00, r, cyc);
        check(cyc == 1 && r == 8'h3C, "R7 write hit updates line", int'(r), 8'h3C);
        check(rd_beats == b0, "R7 no fetch on write hit", rd_beats - b0, 0);

        // write miss: addr 40 -> index 0, tag 5; line 0 holds addr 0/1
        b0 = rd_beats;
        access(1'b1, 8'd40, 8'h77, r, cyc);
        check(cyc == 3, "R6 write miss latency", cyc, 3);
        check(bmem[40] == 8'h77, "R6 write miss memory", int'(bmem[40]), 8'h77);
        check(rd_beats == b0, "R8 no allocate", rd_beats - b0, 0);
        access(1'b0, 8'd0, 8'h00, r, cyc);
        check(cyc == 1 && r == 8'hA5, "R8 resident line kept", cyc, 1);
        access(1'b0, 8'd40, 8'h00, r, cyc);
        check(cyc == 6 && r == 8'h77, "R8 later read misses", cyc, 6);
        access(1'b0, 8'd0, 8'h00, r, cyc);
        check(cyc == 6, "R5 evicted line misses", cyc, 6);

        // reset clears valid bits
        do_reset();
        access(1'b0, 8'd3, 8'h00, r, cyc);
        check(cyc == 6, "R2 miss after reset", cyc, 6);
        check(r == 8'hA6, "R2 data after reset", int'(r), 8'hA6);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule